// File: doc/BRIEF.md
# Field-Split Bit-Vector Multi-Match Packet Classifier

This block compares each incoming packet header tuple with a set of rules and reports every rule that accepts the packet. It does not pick a single winner. The tuple is the source address, destination address, source port, destination port and protocol. These are concatenated into one key and cut into 4-bit subfields.

Each subfield drives a 16-entry table. Each table entry is a bit vector with one bit per rule. Bit i of entry v is set when rule i accepts the value v in that subfield. The vectors read from all the tables are ANDed in a registered binary tree. A bit that survives the tree marks a rule that accepted every subfield. Storage therefore grows linearly with the rule count, and one tuple can enter every clock cycle.

Rules are written while classification runs. A single update cycle rewrites one rule's column in every subfield table. The rule is given as a value and a care mask: care bit 1 means that key bit is compared, and care bit 0 means it is ignored. Turning the ternary rule into per-entry bits is done in hardware. Converting ranges or prefixes into value/care pairs is left to software.

Top module: `mm_hdr_classifier`

## Requirements
- R1: The key is `{hdr_src, hdr_dst, hdr_sport, hdr_dport, hdr_proto}`, with hdr_proto in the least significant bits. Subfield k is key bits [4k+3:4k]. Bit i of `out_vec` is 1 exactly when rule i is active and `((key ^ val_i) & care_i) == 0`. `val_i` and `care_i` use the same bit order as the key.
- R2: Every matching rule is reported at once in `out_vec`. No priority is applied.
- R3: `out_valid` rises exactly 6 clock edges after the edge that samples `in_valid`, counting that sampling edge as the first. This latency is 1 + ceil(log2(number of subfields)). The vector presented with `out_valid` belongs to that tuple.
- R4: `out_any` is 1 exactly when `out_valid` is 1 and at least one bit of `out_vec` is 1.
- R5: After reset, no rule is active, `out_valid` is 0, and a lookup returns an all-zero vector.
- R6: When `upd_en` is 1 at an edge, rule `upd_rule` is rewritten from `upd_val`/`upd_care`. A tuple sampled at a later edge sees the new rule.
- R7: A tuple sampled at the same edge as an update sees the rule set as it was before that update.
- R8: An update with `upd_active` = 0 disables the rule. The rule then matches no tuple.
- R9: An update changes only the bit of rule `upd_rule`. All other rules keep their match behaviour.
- R10: While `out_valid` is 0, `out_vec` is all zero.
- R11: A new tuple can be accepted every cycle. Back-to-back tuples produce back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header tuple valid |
| hdr_src | input | 32 | Source address |
| hdr_dst | input | 32 | Destination address |
| hdr_sport | input | 16 | Source port |
| hdr_dport | input | 16 | Destination port |
| hdr_proto | input | 8 | Protocol number |
| upd_en | input | 1 | Rule update strobe |
| upd_rule | input | 3 | Index of the rule to rewrite |
| upd_active | input | 1 | 1 = rule enabled, 0 = rule disabled |
| upd_val | input | 104 | Rule compare value, key bit order |
| upd_care | input | 104 | Rule care mask, 1 = bit compared |
| out_valid | output | 1 | Result valid |
| out_vec | output | 8 | One bit per rule that matched |
| out_any | output | 1 | At least one rule matched |

## Verification
A lookup and a rule update can land on the same clock edge. The read must then see the table contents from before the write, and the following tuple must see the contents after it. The bench presents a tuple together with an update that disables a rule the tuple hits. It also presents a tuple together with an update that enables a rule the tuple would hit. In both cases it repeats the same tuple on the next cycle. The first result is judged against a rule model captured before the update is applied, and the second against the model after it.

// File: rtl/mmc_pkg.sv
package mmc_pkg;
  localparam int SUB_W       = 4;
  localparam int SUB_ENTRIES = 1 << SUB_W;

  // Does a table entry value satisfy a value/care nibble?
  function automatic logic nib_hit(input logic [SUB_W-1:0] entry,
                                   input logic [SUB_W-1:0] val,
                                   input logic [SUB_W-1:0] care);
    return ((entry ^ val) & care) == '0;
  endfunction

  // Registered levels in the reduction tree
  function automatic int tree_depth(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/mmc_subtable.sv
module mmc_subtable
  import mmc_pkg::*;
#(
  parameter int NRULES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SUB_W-1:0]          rd_nib,
  output logic [NRULES-1:0]         rd_vec,
  input  logic                      wr_en,
  input  logic [$clog2(NRULES)-1:0] wr_rule,
  input  logic                      wr_active,
  input  logic [SUB_W-1:0]          wr_val,
  input  logic [SUB_W-1:0]          wr_care
);
  logic [NRULES-1:0] tbl [SUB_ENTRIES];

  // Read uses the contents before any write on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < SUB_ENTRIES; e++) tbl[e] <= '0;
      rd_vec <= '0;
    end else begin
      if (wr_en) begin
        for (int e = 0; e < SUB_ENTRIES; e++)
          tbl[e][wr_rule] <= wr_active & nib_hit(SUB_W'(e), wr_val, wr_care);
      end
      rd_vec <= tbl[rd_nib];
    end
  end

  // R8: a disabled rule reads back as zero two edges later
  a_r8_disabled_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && !$past(wr_active, 2)) |-> !rd_vec[$past(wr_rule, 2)]);

  // R6: a fully ignored nibble of an active rule reads back as one
  a_r6_wildcard_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en, 2) && $past(wr_active, 2) && ($past(wr_care, 2) == '0))
      |-> rd_vec[$past(wr_rule, 2)]);
endmodule

// File: rtl/mmc_and_tree.sv
module mmc_and_tree
  import mmc_pkg::*;
#(
  parameter int NRULES = 8,
  parameter int NIN    = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_in,
  input  logic [NRULES-1:0] vec_in [NIN],
  output logic              vld_out,
  output logic [NRULES-1:0] vec_out
);
  localparam int LV = tree_depth(NIN);
  localparam int P  = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int W = P >> l;
    logic [NRULES-1:0] node [W];
    logic              vld;
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < W; j++) begin : g_pad
        if (j < NIN) begin : g_in
          assign node[j] = vec_in[j];
        end else begin : g_one
          assign node[j] = '1;
        end
      end
      assign vld = vld_in;
    end else begin : g_red
      always_ff @(posedge clk) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= g_lv[l-1].vld;
      end
      for (genvar j = 0; j < W; j++) begin : g_pair
        always_ff @(posedge clk)
          node[j] <= g_lv[l-1].node[2*j] & g_lv[l-1].node[2*j+1];
      end
    end
  end

  assign vld_out = g_lv[LV].vld;
  assign vec_out = g_lv[LV].node[0];
endmodule

// File: rtl/mm_hdr_classifier.sv
module mm_hdr_classifier
  import mmc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 16,
  parameter int PROTO_W = 8,
  parameter int NRULES  = 8,
  localparam int KEY_W  = 2*ADDR_W + 2*PORT_W + PROTO_W,
  localparam int RIDX_W = $clog2(NRULES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  hdr_src,
  input  logic [ADDR_W-1:0]  hdr_dst,
  input  logic [PORT_W-1:0]  hdr_sport,
  input  logic [PORT_W-1:0]  hdr_dport,
  input  logic [PROTO_W-1:0] hdr_proto,
  input  logic               upd_en,
  input  logic [RIDX_W-1:0]  upd_rule,
  input  logic               upd_active,
  input  logic [KEY_W-1:0]   upd_val,
  input  logic [KEY_W-1:0]   upd_care,
  output logic               out_valid,
  output logic [NRULES-1:0]  out_vec,
  output logic               out_any
);
  localparam int NSUB = KEY_W / SUB_W;
  localparam int LAT  = 1 + tree_depth(NSUB);

  logic [KEY_W-1:0]  key;
  logic [NRULES-1:0] sub_vec [NSUB];
  logic              look_vld;
  logic              tree_vld;
  logic [NRULES-1:0] tree_vec;

  assign key = {hdr_src, hdr_dst, hdr_sport, hdr_dport, hdr_proto};

  // Valid follows the one-cycle table read
  always_ff @(posedge clk) begin
    if (!rst_n) look_vld <= 1'b0;
    else        look_vld <= in_valid;
  end

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    mmc_subtable #(.NRULES(NRULES)) u_tbl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_nib   (key[k*SUB_W +: SUB_W]),
      .rd_vec   (sub_vec[k]),
      .wr_en    (upd_en),
      .wr_rule  (upd_rule),
      .wr_active(upd_active),
      .wr_val   (upd_val[k*SUB_W +: SUB_W]),
      .wr_care  (upd_care[k*SUB_W +: SUB_W])
    );
  end

  mmc_and_tree #(.NRULES(NRULES), .NIN(NSUB)) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_in (look_vld),
    .vec_in (sub_vec),
    .vld_out(tree_vld),
    .vec_out(tree_vec)
  );

  assign out_valid = tree_vld;
  assign out_vec   = tree_vld ? tree_vec : '0;
  assign out_any   = |out_vec;

  // R3: fixed latency in both directions
  a_r3_valid_after_lat: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid, LAT) |-> out_valid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, LAT));
  // R4: flag only with a valid, non-empty result
  a_r4_any_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_any |-> (out_valid && out_vec != '0));
endmodule

// File: tb/tb_mm_hdr_classifier.sv
module tb_mm_hdr_classifier;
  localparam int KW = 104;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [KW-1:0] hkey = '0;
  logic upd_en = 1'b0;
  logic [2:0] upd_rule = '0;
  logic upd_active = 1'b0;
  logic [KW-1:0] upd_val = '0, upd_care = '0;
  logic out_valid, out_any;
  logic [NR-1:0] out_vec;

  always #2 clk = ~clk;

  mm_hdr_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .hdr_src(hkey[103:72]), .hdr_dst(hkey[71:40]), .hdr_sport(hkey[39:24]),
    .hdr_dport(hkey[23:8]), .hdr_proto(hkey[7:0]),
    .upd_en(upd_en), .upd_rule(upd_rule), .upd_active(upd_active),
    .upd_val(upd_val), .upd_care(upd_care),
    .out_valid(out_valid), .out_vec(out_vec), .out_any(out_any));

  int total = 0, bad = 0;
  bit done = 0;

  // rule model
  logic [KW-1:0] m_val [NR];
  logic [KW-1:0] m_care [NR];
  logic m_act [NR];

  // scoreboard
  logic [NR-1:0] exp_q [128];
  string tag_q [128];
  int wr_i = 0, rd_i = 0;

  function automatic logic [KW-1:0] mk(input logic [31:0] s, input logic [31:0] d,
                                       input logic [15:0] sp, input logic [15:0] dp,
                                       input logic [7:0] pr);
    return {s, d, sp, dp, pr};
  endfunction

  function automatic logic [NR-1:0] model(input logic [KW-1:0] k);
    logic [NR-1:0] r = '0;
    for (int i = 0; i < NR; i++)
      r[i] = m_act[i] && (((k ^ m_val[i]) & m_care[i]) == '0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [NR-1:0] act,
                     input logic [NR-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle of stimulus; expected result taken from the model before the update
  task automatic step(input bit iv, input logic [KW-1:0] k, input string tag,
                      input bit ue, input int rule, input bit act,
                      input logic [KW-1:0] v, input logic [KW-1:0] c);
    in_valid = iv; hkey = k;
    upd_en = ue; upd_rule = 3'(rule); upd_active = act; upd_val = v; upd_care = c;
    if (iv) begin exp_q[wr_i] = model(k); tag_q[wr_i] = tag; wr_i++; end
    if (ue) begin m_act[rule] = act; m_val[rule] = v; m_care[rule] = c; end
    @(negedge clk);
    in_valid = 0; upd_en = 0;
  endtask

  task automatic look(input logic [KW-1:0] k, input string tag);
    step(1, k, tag, 0, 0, 0, '0, '0);
  endtask

  task automatic rule(input int r, input bit act, input logic [KW-1:0] v,
                      input logic [KW-1:0] c);
    step(0, '0, "", 1, r, act, v, c);
  endtask

  task automatic drain;
    repeat (8) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_i >= wr_i) chk(0, "R3 unexpected result", out_vec, '0);
      else begin
        chk(out_vec == exp_q[rd_i], tag_q[rd_i], out_vec, exp_q[rd_i]);
        chk(out_any == (exp_q[rd_i] != '0), "R4 any flag", {7'd0, out_any},
            {7'd0, exp_q[rd_i] != '0});
        rd_i++;
      end
    end
  end

  // Table walk: headers and hand-worked expected vectors for the rule set below
  localparam logic [KW-1:0] HDR [5] = '{
    {32'h0A000001, 32'hC0A80105, 16'h1F90, 16'h0050, 8'h06},
    {32'h0B000001, 32'h00000000, 16'h0000, 16'h0050, 8'h11},
    {32'h0A123456, 32'hC0A801FF, 16'h1F91, 16'h0051, 8'h06},
    {32'hFFFFFFFF, 32'hC0A80205, 16'h1F90, 16'h0050, 8'h11},
    {32'h0A000001, 32'hC0A80105, 16'h0000, 16'h0000, 8'h00}};
  localparam logic [NR-1:0] EXPV [5] = '{8'hBF, 8'h08, 8'h1B, 8'h28, 8'h99};

  initial begin
    for (int i = 0; i < NR; i++) begin m_act[i] = 0; m_val[i] = '0; m_care[i] = '0; end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 / R10: reset state
    chk(out_valid == 0, "R5 valid after reset", {7'd0, out_valid}, 8'h00);
    chk(out_vec == 0, "R10 idle vector", out_vec, 8'h00);
    look(HDR[0], "R5 empty rule set");
    drain;

    // R6 / R8: program rules
    rule(0, 1, mk(32'h0A000000, 0, 0, 0, 0), mk(32'hFF000000, 0, 0, 0, 0));
    rule(1, 1, mk(0, 0, 0, 0, 8'h06), mk(0, 0, 0, 0, 8'hFF));
    rule(2, 1, mk(0, 0, 0, 16'h0050, 8'h06), mk(0, 0, 0, 16'hFFFF, 8'hFF));
    rule(3, 1, '0, '0);
    rule(4, 1, mk(0, 32'hC0A80100, 0, 0, 0), mk(0, 32'hFFFFFF00, 0, 0, 0));
    rule(5, 1, mk(0, 0, 16'h1F90, 0, 0), mk(0, 0, 16'hFFFF, 0, 0));
    rule(6, 0, '0, '0);
    rule(7, 1, mk(32'h0A000001, 32'hC0A80105, 0, 0, 0),
               mk(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0));

    // R1 / R2 / R11: back-to-back table walk, expected values from the table
    for (int t = 0; t < 5; t++) begin
      in_valid = 1; hkey = HDR[t];
      exp_q[wr_i] = EXPV[t]; tag_q[wr_i] = "R1 R2 R11 table walk"; wr_i++;
      @(negedge clk);
    end
    in_valid = 0;
    drain;

    // R3: latency count
    look(HDR[1], "R3 latency data");
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R3 not early", {7'd0, out_valid}, 8'h00);
    @(negedge clk);
    chk(out_valid == 1, "R3 on time", {7'd0, out_valid}, 8'h01);
    drain;

    // R7: lookup and update on the same edge, then the same tuple again
    step(1, HDR[0], "R7 disable same cycle sees old", 1, 1, 0, '0, '0);
    look(HDR[0], "R6 R8 next cycle sees disable");
    step(1, HDR[1], "R7 enable same cycle sees old", 1, 6, 1, '0, '0);
    look(HDR[1], "R6 next cycle sees enable");
    drain;

    // R9: rewrite one rule, others unchanged
    rule(0, 1, mk(32'h0B000000, 0, 0, 0, 0), mk(32'hFF000000, 0, 0, 0, 0));
    look(HDR[1], "R9 rewritten rule hits");
    look(HDR[0], "R9 other rules kept");
    look(HDR[2], "R9 other rules kept");
    drain;

    // R4 / R10: nothing matches
    rule(3, 0, '0, '0);
    rule(6, 0, '0, '0);
    look(mk(32'hFFFFFFFF, 0, 0, 0, 8'h11), "R4 no match flag low");
    drain;
    chk(out_vec == 0, "R10 idle vector", out_vec, 8'h00);
    chk(rd_i == wr_i, "R11 all results arrived", 8'(rd_i), 8'(wr_i));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule